// File: doc/BRIEF.md
# Receive HDB3 Decoder with Alarms

This block sits on the receive side of a 2.048 Mbit/s line interface. It sits after the analog slicer and the clock recovery loop. One positive-pulse bit and one negative-pulse bit arrive on each recovered clock edge. In single-rail use, the block merges the two pulse streams into one NRZ data stream. When HDB3 decoding is enabled, it removes the zero-substitution sequences and writes the four original zeros back in their place. In the same mode it raises a one-cycle violation flag for every coding error it sees.

A digital loss-of-signal monitor counts zeros in the recovered data. A receive alarm-indication control replaces the terminal-side data with all ones. An active-low alarm-test input drives both alarm outputs into their alarm state and leaves the data path untouched.

In dual-rail use, the two pulse streams go straight through with the same latency and without decoding. A second polarity mode makes the rail outputs active low and inverts the receive clock output. Every data path goes through a four-symbol window, so a substitution can be recognised before its first pulse leaves the block.

Top module: `rx_line_decoder`

## Requirements
- R1: In single-rail mode, a symbol with a 1 on either rail gives an output data 1 and an empty symbol gives a 0. The data for a symbol sampled at clock edge k appears on `rx_data` after edge k+4. `rx_nrail` stays 0.
- R2: With `hdb3_en`=1 in single-rail mode, two patterns each come out as four zeros. The first is zero, zero, zero, then a mark with the same polarity as the previous mark. The second is a mark, zero, zero, then a mark with the same polarity as that first mark, where the first mark was not itself a removed substitution pulse.
- R3: With `hdb3_en`=0 in single-rail mode, a mark whose polarity matches the previous mark is flagged on `viol`. Zeros between the two marks do not matter, and the first mark after reset is never flagged.
- R4: With `hdb3_en`=1, a same-polarity mark is flagged only when it does not complete a pattern from R2. Valid substitutions raise no flag.
- R5: For a symbol sampled at edge k, `viol` is high for exactly the one cycle after edge k+1.
- R6: `los_n` goes to 0 on the edge that puts the 33rd consecutive zero on the decoded data output. It returns to 1 on the edge that outputs the next 1.
- R7: While `los_n`=0 in single-rail mode and `ais_req`=0, `rx_data` is 0.
- R8: In single-rail mode, `ais_req`=1 sets `rx_data` to 1 at once, whatever the line or alarm state.
- R9: With `dual_rail`=1, `rx_data` carries the positive rail and `rx_nrail` the negative rail with the latency of R1. `hdb3_en` is ignored and `viol` stays 0 unless the alarm test forces it.
- R10: With `dual_rail`=1 and `inv_mode`=1, both rail outputs are inverted and `rclk_out` is the inverse of `clk`. Otherwise `rclk_out` equals `clk`.
- R11: In dual-rail mode, `ais_req`=1 drives both rails to logical 1. That is pin level 1 when `inv_mode`=0 and pin level 0 when `inv_mode`=1.
- R12: `alm_test_n`=0 forces `viol`=1 and `los_n`=0 and leaves the data outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_p | input | 1 | Positive-pulse symbol bit |
| rail_n | input | 1 | Negative-pulse symbol bit |
| hdb3_en | input | 1 | HDB3 decoding enable (single-rail only) |
| dual_rail | input | 1 | 1 selects dual-rail pass-through |
| inv_mode | input | 1 | Dual-rail active-low polarity mode |
| ais_req | input | 1 | Replace terminal data with all ones |
| alm_test_n | input | 1 | Active-low alarm test |
| rx_data | output | 1 | Decoded data, or positive rail in dual-rail mode |
| rx_nrail | output | 1 | Negative rail in dual-rail mode, 0 otherwise |
| viol | output | 1 | Violation flag, one cycle per event |
| los_n | output | 1 | Digital loss of signal, active low |
| rclk_out | output | 1 | Receive clock toward the terminal |

## Verification
Three results have fixed delays after the edge that samples a symbol. Decoded or passed-through data appears after edge k+4 and the violation flag after edge k+1. The loss-of-signal flag changes on the same edge as the data bit that triggers it.

The bench drives a new symbol at each falling edge, one nanosecond after the edge. At that same falling edge it compares `rx_data` against the symbol five steps back and `viol` against the symbol two steps back. Every compare therefore falls on a settled cycle.

The alarm-indication, alarm-test and clock-polarity results are combinational. They are checked one nanosecond after the control input changes, at a falling edge, with no clock edge in between.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // Symbol held in the decode window: rail bits plus a removal mark.
  typedef struct packed {
    logic p;
    logic n;
    logic kill;
  } rx_sym_t;

  localparam int WIN = 4;  // substitution sequences span four symbols

  function automatic logic sym_mark(rx_sym_t s);
    return s.p | s.n;
  endfunction

  // Positive rail wins if both rails are set in one symbol.
  function automatic logic sym_pol(rx_sym_t s);
    return s.p;
  endfunction

  function automatic logic [31:0] zero_run_next(logic [31:0] run, logic bit_v,
                                                logic [31:0] cap);
    if (bit_v) return 32'd0;
    if (run >= cap) return cap;
    return run + 32'd1;
  endfunction

endpackage

// File: rtl/rxd_hdb3_window.sv
module rxd_hdb3_window
  import rxd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_p,
  input  logic in_n,
  input  logic hdb_on,
  input  logic flag_en,
  output logic bit_d,
  output logic dec_q,
  output logic rp_q,
  output logic rn_q,
  output logic viol_q,
  output logic hit
);

  rx_sym_t          st [WIN];
  logic [WIN-1:0]   m;
  logic [WIN-1:0]   pol;
  logic             last_pol, last_vld;
  logic             prev_pol, prev_vld;
  logic             same_pol, mid_zero, hit_b00v, viol_d;

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      m[i]   = sym_mark(st[i]);
      pol[i] = sym_pol(st[i]);
    end
  end

  // Polarity of the mark preceding the newest symbol: newest in window wins.
  always_comb begin
    prev_vld = last_vld;
    prev_pol = last_pol;
    for (int i = WIN - 1; i >= 1; i--) begin
      if (m[i]) begin
        prev_vld = 1'b1;
        prev_pol = pol[i];
      end
    end
  end

  assign same_pol = m[0] & prev_vld & (pol[0] == prev_pol);
  assign mid_zero = ~|m[WIN-2:1];
  // 000V (oldest empty) or B00V (oldest a live mark of the same polarity)
  assign hit      = hdb_on & same_pol & mid_zero & ~(m[WIN-1] & st[WIN-1].kill);
  assign hit_b00v = hit & m[WIN-1];
  assign viol_d   = flag_en & same_pol & ~hit;
  assign bit_d    = m[WIN-1] & ~st[WIN-1].kill & ~hit_b00v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) st[i] <= '0;
      last_pol <= 1'b0;
      last_vld <= 1'b0;
      dec_q    <= 1'b0;
      rp_q     <= 1'b0;
      rn_q     <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      st[0] <= {in_p, in_n, 1'b0};
      st[1] <= {st[0].p, st[0].n, st[0].kill | hit};
      for (int i = 2; i < WIN; i++) st[i] <= st[i-1];
      if (m[WIN-1]) begin
        last_pol <= pol[WIN-1];
        last_vld <= 1'b1;
      end
      dec_q  <= bit_d;
      rp_q   <= st[WIN-1].p;
      rn_q   <= st[WIN-1].n;
      viol_q <= viol_d;
    end
  end

  // R2: a removal mark only ever follows a recognised substitution
  assert_kill_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st[1].kill |-> $past(hit));

  // R5: every violation pulse stems from a mark entering the window
  assert_viol_from_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> $past(m[0]));

endmodule

// File: rtl/rxd_los_detect.sv
module rxd_los_detect
  import rxd_pkg::*;
#(
  parameter int ZERO_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_d,
  output logic los_q
);

  localparam int CW = $clog2(ZERO_LIMIT + 2);
  localparam logic [31:0] CAP = 32'(ZERO_LIMIT + 1);

  logic [CW-1:0] run_q;
  logic [31:0]   run_d;

  assign run_d = zero_run_next(32'(run_q), bit_d, CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      los_q <= 1'b0;
    end else begin
      run_q <= CW'(run_d);
      los_q <= (run_d > 32'(ZERO_LIMIT));
    end
  end

  // R6: loss of signal only while the bit just output was a zero
  assert_los_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    los_q |-> $past(!bit_d));

endmodule

// File: rtl/rxd_out_sel.sv
module rxd_out_sel (
  input  logic clk,
  input  logic dual_rail,
  input  logic inv_mode,
  input  logic ais_req,
  input  logic alm_test_n,
  input  logic dec_q,
  input  logic rp_q,
  input  logic rn_q,
  input  logic los_q,
  input  logic viol_q,
  output logic rx_data,
  output logic rx_nrail,
  output logic viol,
  output logic los_n,
  output logic rclk_out
);

  logic flip;
  logic lp, ln;

  assign flip = dual_rail & inv_mode;
  assign lp   = ais_req | rp_q;
  assign ln   = ais_req | rn_q;

  always_comb begin
    if (dual_rail) begin
      rx_data  = lp ^ flip;
      rx_nrail = ln ^ flip;
    end else begin
      rx_data  = ais_req | (dec_q & ~los_q);
      rx_nrail = 1'b0;
    end
  end

  assign viol     = ~alm_test_n | viol_q;
  assign los_n    = alm_test_n & ~los_q;
  assign rclk_out = clk ^ flip;

endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder #(
  parameter int ZERO_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_p,
  input  logic rail_n,
  input  logic hdb3_en,
  input  logic dual_rail,
  input  logic inv_mode,
  input  logic ais_req,
  input  logic alm_test_n,
  output logic rx_data,
  output logic rx_nrail,
  output logic viol,
  output logic los_n,
  output logic rclk_out
);

  logic bit_d, dec_q, rp_q, rn_q, viol_q, sub_hit, los_q;

  rxd_hdb3_window win_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_p    (rail_p),
    .in_n    (rail_n),
    .hdb_on  (hdb3_en & ~dual_rail),
    .flag_en (~dual_rail),
    .bit_d   (bit_d),
    .dec_q   (dec_q),
    .rp_q    (rp_q),
    .rn_q    (rn_q),
    .viol_q  (viol_q),
    .hit     (sub_hit)
  );

  rxd_los_detect #(.ZERO_LIMIT(ZERO_LIMIT)) los_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_d (bit_d),
    .los_q (los_q)
  );

  rxd_out_sel sel_i (
    .clk        (clk),
    .dual_rail  (dual_rail),
    .inv_mode   (inv_mode),
    .ais_req    (ais_req),
    .alm_test_n (alm_test_n),
    .dec_q      (dec_q),
    .rp_q       (rp_q),
    .rn_q       (rn_q),
    .los_q      (los_q),
    .viol_q     (viol_q),
    .rx_data    (rx_data),
    .rx_nrail   (rx_nrail),
    .viol       (viol),
    .los_n      (los_n),
    .rclk_out   (rclk_out)
  );

  // R7: single-rail data held low during loss of signal
  assert_los_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_rail && !ais_req && alm_test_n && !los_n) |-> !rx_data);

  // R8: alarm indication overrides single-rail data
  assert_ais_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_rail && ais_req) |-> rx_data);

  // R9: dual-rail mode raises no violations once the window has refilled
  assert_dual_no_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_rail && $past(dual_rail) && alm_test_n) |-> !viol);

  // R2: a substitution hit clears the next decoded bit
  assert_sub_clears_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_hit && !dual_rail) |-> !bit_d);

endmodule

// File: tb/rx_line_decoder_tb_top.sv
module rx_line_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        hdb;
    logic [15:0] p;
    logic [15:0] n;
    logic [15:0] data;
    logic [15:0] vio;
  } vec_t;

  // bit i of each field is symbol i in time order
  localparam vec_t VECS [0:7] = '{
    '{1'b0, 16'h0045, 16'h0092, 16'h00D7, 16'h0000},  // plain AMI
    '{1'b0, 16'h0143, 16'h0028, 16'h016B, 16'h0122},  // AMI violations
    '{1'b1, 16'h0011, 16'h0020, 16'h0021, 16'h0000},  // 000V
    '{1'b1, 16'h0042, 16'h0025, 16'h0043, 16'h0000},  // B00V
    '{1'b1, 16'h0011, 16'h0006, 16'h0017, 16'h0004},  // code violation
    '{1'b0, 16'h0011, 16'h0000, 16'h0011, 16'h0010},  // 000V seen as AMI error
    '{1'b1, 16'h0008, 16'h0000, 16'h0008, 16'h0000},  // V with no prior mark
    '{1'b1, 16'h0011, 16'h0120, 16'h0001, 16'h0000}   // 000V then B00V
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rp = 1'b0, rn = 1'b0, hdb = 1'b0, dual = 1'b0, inv = 1'b0;
  logic ais = 1'b0, almn = 1'b1;
  logic rx_data, rx_nrail, viol, los_n, rclk_out;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_line_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .rail_p(rp), .rail_n(rn), .hdb3_en(hdb),
    .dual_rail(dual), .inv_mode(inv), .ais_req(ais), .alm_test_n(almn),
    .rx_data(rx_data), .rx_nrail(rx_nrail), .viol(viol), .los_n(los_n),
    .rclk_out(rclk_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rp = 0; rn = 0; ais = 0; almn = 1;
    repeat (2) step();
    rst_n = 1'b1;
  endtask

  initial begin
    // reset state
    do_reset();
    chk("R1 reset rx_data", rx_data, 1'b0);
    chk("R1 reset rx_nrail", rx_nrail, 1'b0);
    chk("R5 reset viol", viol, 1'b0);
    chk("R6 reset los_n", los_n, 1'b1);

    // vector table walk
    foreach (VECS[v]) begin
      hdb = VECS[v].hdb;
      dual = 0; inv = 0;
      do_reset();
      for (int t = 0; t <= 20; t++) begin
        step();
        if (t >= 5)
          chk(VECS[v].hdb ? "R2,R4 data" : "R1,R3 data", rx_data, VECS[v].data[t-5]);
        if (t >= 2 && t - 2 < 16)
          chk(VECS[v].hdb ? "R4,R5 viol" : "R3,R5 viol", viol, VECS[v].vio[t-2]);
        rp = (t < 16) ? VECS[v].p[t] : 1'b0;
        rn = (t < 16) ? VECS[v].n[t] : 1'b0;
      end
    end

    // loss of signal, forcing low, AIS over LOS
    hdb = 0; dual = 0; inv = 0;
    do_reset();
    for (int t = 0; t <= 44; t++) begin
      step();
      if (t == 37) chk("R6 los before 33 zeros", los_n, 1'b1);
      if (t == 38) chk("R6 los after 33 zeros", los_n, 1'b0);
      if (t == 38) chk("R7 data low in los", rx_data, 1'b0);
      if (t == 40) chk("R8 ais during los", rx_data, 1'b1);
      if (t == 40) chk("R6 los kept under ais", los_n, 1'b0);
      if (t == 42) chk("R7 data low after ais", rx_data, 1'b0);
      if (t == 42) chk("R6 los held", los_n, 1'b0);
      if (t == 43) chk("R6 los cleared by mark", los_n, 1'b1);
      if (t == 43) chk("R1 mark after los", rx_data, 1'b1);
      rp = (t == 0 || t == 38);
      if (t == 39) ais = 1'b1;
      if (t == 41) ais = 1'b0;
    end

    // alarm test
    do_reset();
    almn = 1'b0;
    for (int t = 0; t <= 7; t++) begin
      step();
      if (t == 1) chk("R12 viol forced", viol, 1'b1);
      if (t == 1) chk("R12 los forced", los_n, 1'b0);
      if (t == 5) chk("R12 data unaffected 1", rx_data, 1'b1);
      if (t == 6) chk("R12 data unaffected 0", rx_data, 1'b0);
      if (t == 7) chk("R12 viol released", viol, 1'b0);
      if (t == 7) chk("R12 los released", los_n, 1'b1);
      rp = (t == 0);
      if (t == 6) almn = 1'b1;
    end

    // dual rail, both polarities: symbols + + 0 -
    for (int m = 0; m < 2; m++) begin
      logic [3:0] pp = 4'b0011, nn = 4'b1000;
      dual = 1; hdb = 1; inv = logic'(m);
      do_reset();
      chk(m ? "R10 rclk inverted" : "R10 rclk direct", rclk_out, logic'(m));
      for (int t = 0; t <= 9; t++) begin
        step();
        if (t >= 5 && t - 5 < 4) begin
          chk(m ? "R10 p rail inv" : "R9 p rail", rx_data, pp[t-5] ^ logic'(m));
          chk(m ? "R10 n rail inv" : "R9 n rail", rx_nrail, nn[t-5] ^ logic'(m));
        end
        chk("R9 no viol in dual", viol, 1'b0);
        rp = (t < 4) ? pp[t] : 1'b0;
        rn = (t < 4) ? nn[t] : 1'b0;
      end
      ais = 1'b1;
      #1;
      chk("R11 ais p rail", rx_data, ~logic'(m));
      chk("R11 ais n rail", rx_nrail, ~logic'(m));
      ais = 1'b0;
    end

    // AIS in single-rail idle
    dual = 0; inv = 0; hdb = 0;
    do_reset();
    ais = 1'b1;
    #1;
    chk("R8 ais single", rx_data, 1'b1);
    ais = 1'b0;
    #1;
    chk("R8 ais released", rx_data, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule